// File: doc/BRIEF.md
# Bus Clock Speed Calibrator

This block works out how fast the bus clock runs. A timer elsewhere in the chip divides the bus clock into ticks and drives a slow square wave from them. Each half of the wave lasts a fixed number of ticks. The calibrator watches the wave's sampled level and timestamps chosen rising edges against a free-running reference counter of known frequency. From those timestamps it computes the length of one timer tick in nanoseconds.

The result passes through sanity bounds. A value outside the window, or a wave that stops toggling, is replaced by a default that assumes a fast bus, and a fallback flag is raised. From the accepted or substituted tick length the block picks which of two serial-port input clock rates applies. Other blocks then use these outputs to set baud divisors and timer counts.

A single start pulse runs one calibration. The outputs update together, in the cycle where the one-cycle `done` pulse is high.

Top module: `bus_speed_cal`

## Requirements
- R1: After reset, `done` is 0, `fallback` is 0, `tick_ns` is 7878 and `uart_clk_hz` is 66666667.
- R2: An edge is a low-to-high change of `wave_level` seen after start. The level seen just before the first sample counts as high, so a wave that is already high at start does not produce an edge.
- R3: The start timestamp is the `ref_count` value at the 2nd rising edge. The end timestamp is the value at the 258th rising edge, so the span covers 256 wave periods.
- R4: The raw result is floor(span × 10^9 / (256 × 2 × 64 × REF_HZ)). The multiplication is done before the division, in full precision.
- R5: A raw result from 6933 to 20800 inclusive is accepted: `tick_ns` takes that value and `fallback` is 0.
- R6: A raw result outside that window is rejected: `tick_ns` becomes 7878 and `fallback` becomes 1.
- R7: `uart_clk_hz` is 66666667 when `tick_ns`/520 is below 20, which means `tick_ns` < 10400. Otherwise it is 33333333.
- R8: A calibration times out when more than TIMEOUT_TICKS reference ticks pass without a rising edge, counted from start or from the last edge. On a timeout the block takes the R6 fallback result.
- R9: `done` is high for exactly one cycle per calibration. `tick_ns`, `fallback` and `uart_clk_hz` change only in a cycle where `done` is high.
- R10: A `start` pulse that arrives while a calibration is running is ignored. The running calibration completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins one calibration when the block is idle |
| wave_level | input | 1 | Sampled level of the tick-derived square wave |
| ref_count | input | TS_W (64) | Free-running reference tick counter |
| tick_ns | output | OUT_W (32) | Timer tick period in nanoseconds |
| fallback | output | 1 | Result is the default substitute |
| uart_clk_hz | output | 32 | Selected serial-port input clock rate in Hz |
| done | output | 1 | One-cycle pulse when the outputs update |

## Verification
The assertions assume four things about the inputs. `wave_level` is already synchronous to `clk`. `ref_count` moves forward by a steady amount between edges and wraps modulo 2^64. Start requests that arrive while a run is in progress are dropped by the block itself, not by the environment. The multiplied span always fits the divider's width.

The bench keeps to these assumptions. It drives the wave and `start` only on falling clock edges, and it advances the reference counter by a constant step within each scenario, beginning close to wrap-around. Each wave period is a whole number of clocks, so every expected span is an exact multiple of the step. The bench pairs wave half-period with reference step to land on either side of the two sanity bounds and of the rate-selection threshold.

// File: rtl/bsc_pkg.sv
// Package: shared state type and constants for the bus clock speed calibrator.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package bsc_pkg;

    // Nanoseconds per second, the scale applied to the span before division.
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    // Bits needed to hold NS_PER_S.
    localparam int SCALE_W = 30;

    // Top-level sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_DIVIDE  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/bsc_edge_window.sv
// Edge window: counts rising edges of the sampled wave and timestamps the first
// counted edge after the discard count and the final edge of the averaging window.
// Flags a timeout when the gap between edges grows too long.
// Assumes: wave is synchronous to clk; ref_now wraps modulo 2^TS_W.
module bsc_edge_window #(
    parameter int TS_W          = 64,
    parameter int DISCARD       = 2,
    parameter int AVG_CYCLES    = 256,
    parameter int TIMEOUT_TICKS = 250_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            wave,
    input  logic [TS_W-1:0] ref_now,
    output logic            fin,
    output logic            timed_out,
    output logic [TS_W-1:0] span
);
    localparam int END_EDGE = DISCARD + AVG_CYCLES;
    localparam int CNT_W    = $clog2(END_EDGE + 1);

    logic             active;
    logic             prev_lvl;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [TS_W-1:0]  t_start;
    logic [TS_W-1:0]  t_last;
    logic [TS_W-1:0]  gap;
    logic             rise;

    // Edge detection, the next count and the time since the last edge.
    always_comb begin
        rise   = active && !prev_lvl && wave;
        cnt_nx = edge_cnt + 1'b1;
        gap    = ref_now - t_last;
    end

    // Window sequencing: arm, count edges, take timestamps, finish or time out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            prev_lvl  <= 1'b1;
            edge_cnt  <= '0;
            t_start   <= '0;
            t_last    <= '0;
            span      <= '0;
            fin       <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (arm) begin
                active    <= 1'b1;
                prev_lvl  <= 1'b1;
                edge_cnt  <= '0;
                t_last    <= ref_now;
                timed_out <= 1'b0;
            end else if (active) begin
                prev_lvl <= wave;
                if (rise) begin
                    edge_cnt <= cnt_nx;
                    t_last   <= ref_now;
                    if (cnt_nx == CNT_W'(DISCARD)) begin
                        t_start <= ref_now;
                    end
                    if (cnt_nx == CNT_W'(END_EDGE)) begin
                        span   <= ref_now - t_start;
                        fin    <= 1'b1;
                        active <= 1'b0;
                    end
                end else if (gap > TS_W'(TIMEOUT_TICKS)) begin
                    fin       <= 1'b1;
                    timed_out <= 1'b1;
                    active    <= 1'b0;
                end
            end
        end
    end

    // The edge count never goes past the end of the window.
    assert_edge_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= CNT_W'(END_EDGE));

    // Completion, whether normal or by timeout, is a single-cycle event.
    assert_fin_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // No new arm is accepted while a window is still open.
    assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !arm);

endmodule

// File: rtl/bsc_divider.sv
// Restoring divider: produces one quotient bit per cycle, NW cycles per result,
// and pulses fin when the quotient is ready.
// Assumes: divisor is non-zero and stays constant while a division runs.
module bsc_divider #(
    parameter int NW = 94,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          fin,
    output logic [NW-1:0] quot
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [DW:0]   trial;
    logic          sub_ok;
    logic [CW-1:0] cnt;
    logic          run;

    // Shift the next dividend bit into the partial remainder and try the subtraction.
    always_comb begin
        trial  = {rem, quot[NW-1]};
        sub_ok = trial >= {1'b0, divisor};
    end

    // One restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quot <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem  <= '0;
                quot <= dividend;
                cnt  <= CW'(NW);
                run  <= 1'b1;
            end else if (run) begin
                if (sub_ok) begin
                    rem  <= DW'(trial - {1'b0, divisor});
                    quot <= {quot[NW-2:0], 1'b1};
                end else begin
                    rem  <= trial[DW-1:0];
                    quot <= {quot[NW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // The partial remainder stays below the divisor throughout a division.
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rem < divisor));

endmodule

// File: rtl/bsc_classify.sv
// Classifier: applies the sanity window to the raw tick period, substitutes the
// default when the value is out of range or a fallback is forced, and picks the
// serial-port input clock rate from the resulting tick period.
// Assumes: purely combinational; the caller registers the outputs.
module bsc_classify #(
    parameter int QW          = 94,
    parameter int OUT_W       = 32,
    parameter int TICK_DIV    = 520,
    parameter int LOW_MHZ     = 25,
    parameter int HIGH_MHZ    = 75,
    parameter int DEFAULT_MHZ = 66,
    parameter int SPLIT_NS    = 20,
    parameter int FAST_HZ     = 66_666_667,
    parameter int SLOW_HZ     = 33_333_333
) (
    input  logic [QW-1:0]    quot,
    input  logic             force_fb,
    output logic [OUT_W-1:0] tick,
    output logic             fb,
    output logic [31:0]      uart_hz
);
    localparam int LO_LIM   = 1000 * TICK_DIV / HIGH_MHZ;
    localparam int HI_LIM   = 1000 * TICK_DIV / LOW_MHZ;
    localparam int DEF_TICK = 1000 * TICK_DIV / DEFAULT_MHZ;
    localparam int SPLIT    = SPLIT_NS * TICK_DIV;

    logic in_range;

    // Check the bounds, substitute the default if needed, then select the rate.
    always_comb begin
        in_range = (quot >= QW'(LO_LIM)) && (quot <= QW'(HI_LIM));
        fb       = force_fb || !in_range;
        tick     = fb ? OUT_W'(DEF_TICK) : quot[OUT_W-1:0];
        uart_hz  = (tick < OUT_W'(SPLIT)) ? 32'(FAST_HZ) : 32'(SLOW_HZ);
    end

endmodule

// File: rtl/bus_speed_cal.sv
// Bus clock speed calibrator top: sequences the edge window, the wide divider
// and the classifier, and registers the result together with a one-cycle done.
// Assumes: wave_level is synchronised to clk; ref_count advances at REF_HZ.
module bus_speed_cal
    import bsc_pkg::*;
#(
    parameter longint unsigned REF_HZ = 64'd25_000_000,
    parameter int TS_W          = 64,
    parameter int OUT_W         = 32,
    parameter int DISCARD       = 2,
    parameter int AVG_CYCLES    = 256,
    parameter int WAVE_COUNT    = 63,
    parameter int TICK_DIV      = 520,
    parameter int LOW_MHZ       = 25,
    parameter int HIGH_MHZ      = 75,
    parameter int DEFAULT_MHZ   = 66,
    parameter int SPLIT_NS      = 20,
    parameter int FAST_HZ       = 66_666_667,
    parameter int SLOW_HZ       = 33_333_333,
    parameter int TIMEOUT_TICKS = 250_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wave_level,
    input  logic [TS_W-1:0]  ref_count,
    output logic [OUT_W-1:0] tick_ns,
    output logic             fallback,
    output logic [31:0]      uart_clk_hz,
    output logic             done
);
    localparam int NW = TS_W + SCALE_W;
    localparam int DW = 64;
    localparam logic [DW-1:0] DIVISOR =
        DW'(AVG_CYCLES) * DW'(2 * (WAVE_COUNT + 1)) * DW'(REF_HZ);
    localparam int DEF_TICK = 1000 * TICK_DIV / DEFAULT_MHZ;
    localparam int LO_LIM   = 1000 * TICK_DIV / HIGH_MHZ;
    localparam int HI_LIM   = 1000 * TICK_DIV / LOW_MHZ;
    localparam int RST_HZ   = (DEF_TICK < SPLIT_NS * TICK_DIV) ? FAST_HZ : SLOW_HZ;

    cal_state_e       state;
    logic             arm;
    logic             win_fin;
    logic             win_to;
    logic [TS_W-1:0]  win_span;
    logic             div_go;
    logic             div_fin;
    logic [NW-1:0]    dividend;
    logic [NW-1:0]    div_quot;
    logic [OUT_W-1:0] cls_tick;
    logic             cls_fb;
    logic [31:0]      cls_hz;

    // Launch the window from idle; launch the divider when a full span is ready.
    always_comb begin
        arm      = (state == ST_IDLE) && start;
        div_go   = (state == ST_MEASURE) && win_fin && !win_to;
        dividend = NW'(win_span) * NW'(NS_PER_S);
    end

    bsc_edge_window #(
        .TS_W(TS_W), .DISCARD(DISCARD), .AVG_CYCLES(AVG_CYCLES),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wave(wave_level),
        .ref_now(ref_count), .fin(win_fin), .timed_out(win_to), .span(win_span)
    );

    bsc_divider #(.NW(NW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dividend),
        .divisor(DIVISOR), .fin(div_fin), .quot(div_quot)
    );

    bsc_classify #(
        .QW(NW), .OUT_W(OUT_W), .TICK_DIV(TICK_DIV), .LOW_MHZ(LOW_MHZ),
        .HIGH_MHZ(HIGH_MHZ), .DEFAULT_MHZ(DEFAULT_MHZ), .SPLIT_NS(SPLIT_NS),
        .FAST_HZ(FAST_HZ), .SLOW_HZ(SLOW_HZ)
    ) u_cls (
        .quot(div_quot), .force_fb(win_to),
        .tick(cls_tick), .fb(cls_fb), .uart_hz(cls_hz)
    );

    // Sequencer and result registers; done pulses when the outputs update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tick_ns     <= OUT_W'(DEF_TICK);
            fallback    <= 1'b0;
            uart_clk_hz <= 32'(RST_HZ);
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_MEASURE;
                end
                ST_MEASURE: begin
                    if (win_fin) begin
                        if (win_to) begin
                            tick_ns     <= cls_tick;
                            fallback    <= cls_fb;
                            uart_clk_hz <= cls_hz;
                            done        <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            state <= ST_DIVIDE;
                        end
                    end
                end
                ST_DIVIDE: begin
                    if (div_fin) begin
                        tick_ns     <= cls_tick;
                        fallback    <= cls_fb;
                        uart_clk_hz <= cls_hz;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // done lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // The result outputs move only together with done.
    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(tick_ns) && $stable(fallback) && $stable(uart_clk_hz)));

    // A flagged result is always the default substitute.
    assert_fallback_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fallback |-> (tick_ns == OUT_W'(DEF_TICK)));

    // An unflagged result always lies inside the sanity window.
    assert_accept_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fallback |-> ((tick_ns >= OUT_W'(LO_LIM)) && (tick_ns <= OUT_W'(HI_LIM))));

endmodule

// File: tb/bus_speed_cal_test.sv
// Directed bench for the bus clock speed calibrator. Each scenario task drives
// the wave and checks the outputs at the following done pulse.
module bus_speed_cal_test;

    localparam longint REF     = 100_000;
    localparam int     TO      = 5000;
    localparam longint DEF     = 7878;
    localparam longint FAST    = 66_666_667;
    localparam longint SLOW    = 33_333_333;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wave = 1'b0;
    logic [63:0] ref_cnt = 64'hFFFF_FFFF_FFF0_0000;
    logic [63:0] step = 64'd1;
    logic [31:0] tick_ns;
    logic        fallback;
    logic [31:0] uart_clk_hz;
    logic        done;

    int checks = 0;
    int errors = 0;

    bus_speed_cal #(.REF_HZ(REF), .TIMEOUT_TICKS(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wave_level(wave),
        .ref_count(ref_cnt), .tick_ns(tick_ns), .fallback(fallback),
        .uart_clk_hz(uart_clk_hz), .done(done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) ref_cnt <= ref_cnt + step;

    task automatic check_val(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected outcome for a span of 512*hs reference ticks.
    task automatic expect_for(int hs, output longint t, output longint fb, output longint hz);
        longint q;
        q = (longint'(512) * hs * 1_000_000_000) / (longint'(32768) * REF);
        if (q < 6933 || q > 20800) begin
            t = DEF; fb = 1;
        end else begin
            t = q; fb = 0;
        end
        hz = (t < 10400) ? FAST : SLOW;
    endtask

    // Run one calibration and check every output against the expectation.
    task automatic run_case(string req, int h, int s, int nrises, bit high0,
                            int restart_at, longint et, longint efb, longint ehz);
        bit got = 0;
        longint a_t = 0, a_fb = 0, a_hz = 0, a_next = 1;
        step = 64'(s);
        wave = high0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                if (high0) repeat (h) @(negedge clk);
                for (int i = 0; i < nrises; i++) begin
                    wave = 1'b0;
                    repeat (h) @(negedge clk);
                    wave = 1'b1;
                    if (i + 1 == restart_at) start = 1'b1;
                    repeat (h) @(negedge clk);
                    start = 1'b0;
                end
                wave = 1'b0;
            end
            begin
                for (int c = 0; c < 20000 && !got; c++) begin
                    @(negedge clk);
                    if (done) begin
                        got  = 1;
                        a_t  = tick_ns;
                        a_fb = fallback;
                        a_hz = uart_clk_hz;
                        @(negedge clk);
                        a_next = done;
                    end
                end
            end
        join
        check_val({req, " R9"}, "done seen", got, 1);
        check_val(req, "tick_ns", a_t, et);
        check_val(req, "fallback", a_fb, efb);
        check_val({req, " R7"}, "uart_clk_hz", a_hz, ehz);
        check_val("R9", "done one cycle", a_next, 0);
        repeat (4) @(negedge clk);
        check_val("R9", "tick_ns held", tick_ns, a_t);
    endtask

    task automatic run_hs(string req, int h, int s);
        longint t, fb, hz;
        expect_for(h * s, t, fb, hz);
        run_case(req, h, s, 258, 1'b0, 0, t, fb, hz);
    endtask

    task automatic test_reset;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", "done", done, 0);
        check_val("R1", "tick_ns", tick_ns, DEF);
        check_val("R1", "fallback", fallback, 0);
        check_val("R1", "uart_clk_hz", uart_clk_hz, FAST);
    endtask

    // R3 R4 R5: fast bus, 7812 ns per tick
    task automatic test_fast_bus;
        run_hs("R3 R4 R5 fast", 5, 10);
    endtask

    // R4 R7: slow bus, 15625 ns per tick
    task automatic test_slow_bus;
        run_hs("R4 R7 slow", 5, 20);
    endtask

    // R7: 10312 selects the fast rate, 10468 the slow one
    task automatic test_split_point;
        run_hs("R7 below split", 6, 11);
        run_hs("R7 above split", 1, 67);
    endtask

    // R5 R6: 20781 accepted, 20937 rejected
    task automatic test_upper_bound;
        run_hs("R5 upper inside", 7, 19);
        run_hs("R6 upper outside", 2, 67);
    endtask

    // R5 R6: 7031 accepted, 6875 rejected
    task automatic test_lower_bound;
        run_hs("R5 lower inside", 5, 9);
        run_hs("R6 lower outside", 4, 11);
    endtask

    // R8: no wave at all ends in the fallback result
    task automatic test_no_wave;
        run_case("R8 no wave", 5, 10, 0, 1'b0, 0, DEF, 1, FAST);
    endtask

    // R2: an initial high level is not an edge, so 257 rises are too few and 258 suffice
    task automatic test_initial_high;
        longint t, fb, hz;
        run_case("R2 R8 high start 257", 5, 10, 257, 1'b1, 0, DEF, 1, FAST);
        expect_for(50, t, fb, hz);
        run_case("R2 high start 258", 5, 10, 258, 1'b1, 0, t, fb, hz);
    endtask

    // R10: a start pulse in the middle of a run does not restart it
    task automatic test_restart_ignored;
        longint t, fb, hz;
        expect_for(50, t, fb, hz);
        run_case("R10 restart ignored", 5, 10, 258, 1'b0, 100, t, fb, hz);
    endtask

    initial begin
        test_reset();
        test_fast_bus();
        test_slow_bus();
        test_split_point();
        test_upper_bound();
        test_lower_bound();
        test_no_wave();
        test_initial_high();
        test_restart_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule